// File: doc/BRIEF.md
# Double-Buffered Framebuffer Access Port

This block gives a processor read access to a pair of 128 KiB frame buffers. At any time one buffer is on display and the other is open to the processor. The processor therefore draws into the hidden buffer while the visible one is scanned out.

Software requests a flip by writing a new frame-select value. The flip is held until the next start of vertical blank. At that point the displayed buffer changes and a vertical-blank interrupt becomes pending. The interrupt stays pending until software acknowledges it.

Reads within the window come in two sizes, 8-bit and 16-bit. Each read returns its data one clock after the request. Bytes are stored swapped inside each 16-bit word. A separate fill port, used by the rendering side, loads buffer contents.

Top module: `fbAccessPort`

## Requirements
- R1: A request hits the window only when `(cpuAddr & 32'h0FFE0000) == 32'h04000000`. The top four address bits are ignored, so every alias in that nibble hits. A request that misses never raises `rdValid`.
- R2: A hit raises `rdValid` for exactly one cycle, on the clock after the request. `rdData` carries the result in that same cycle.
- R3: The processor always reads the buffer not on display, which is buffer `~frameSel`. After reset `frameSel` is 0, so reads come from buffer 1.
- R4: A 16-bit read at window offset `o = cpuAddr[16:0]` returns halfword `o[16:1]` of the selected buffer. Storage holds `2**MEM_AW` halfwords per buffer, and the index is taken modulo that size.
- R5: An 8-bit read applies an XOR of 1 to the offset. At an even offset it returns bits [15:8] of the halfword; at an odd offset it returns bits [7:0]. In both cases `rdData[15:8]` is zero.
- R6: A write to the frame-select control does not change `frameSel`. The written value is held pending until the next `vblankStart` pulse, and `frameSel` takes it on that clock.
- R7: If a control write and `vblankStart` fall in the same cycle, the value applied is the one pending before the write. The new value waits for the next vertical blank.
- R8: `vblankStart` sets `vintPending` on the following clock. `vintPending` is 0 after reset.
- R9: `intAck` clears `vintPending`. If `vblankStart` and `intAck` fall in the same cycle, the set wins.
- R10: `irqOut` equals `vintPending && intEnable`.
- R11: A read in the same cycle as `vblankStart` uses the buffer selection in force before the flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor read request strobe |
| cpuAddr | input | 32 | Processor byte address |
| cpuWide | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| rdValid | output | 1 | Read data valid, one cycle after a hit |
| rdData | output | 16 | Read data; byte reads are zero-extended |
| ctrlWr | input | 1 | Write strobe for the frame-select control |
| ctrlFrameSel | input | 1 | Requested frame-select value |
| vblankStart | input | 1 | One-cycle pulse at the start of vertical blank |
| intEnable | input | 1 | Vertical-blank interrupt enable |
| intAck | input | 1 | Write-one-to-clear acknowledge for the pending bit |
| frameSel | output | 1 | Buffer currently on display |
| vintPending | output | 1 | Vertical-blank interrupt pending |
| irqOut | output | 1 | Interrupt request to the processor |
| fillEn | input | 1 | Fill-port write strobe |
| fillBuf | input | 1 | Fill-port target buffer |
| fillIdx | input | MEM_AW | Fill-port halfword index |
| fillData | input | 16 | Fill-port halfword data |

## Verification
The assertions check the following on every cycle:
- `frameSel` moves only after a vertical-blank pulse.
- A pulse always leaves the interrupt pending.
- The pending bit rises only because of a pulse.
- `irqOut` is never raised without a pending bit.
- Read responses follow requests.
- Byte results are zero-extended.

Other properties need the bench's scenarios, because they depend on buffer contents and event ordering:
- Address aliasing and index wrap.
- The byte-lane swap.
- Which buffer a read lands in before and after a flip.
- Collisions of a control write or an acknowledge with a vertical-blank pulse.

// File: rtl/fbPkg.sv
package fbPkg;
  localparam logic [31:0] WIN_MASK = 32'h0FFE0000;
  localparam logic [31:0] WIN_BASE = 32'h04000000;
  localparam int OFS_W = 17;

  typedef struct packed {
    logic rdGo;
    logic rdByte;
    logic oddByte;
    logic bufSel;
  } ctlStrobes_t;
endpackage

// File: rtl/fbControl.sv
module fbControl
  import fbPkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [31:0]       cpuAddr,
  input  logic              cpuWide,
  input  logic              ctrlWr,
  input  logic              ctrlFrameSel,
  input  logic              vblankStart,
  input  logic              intEnable,
  input  logic              intAck,
  output ctlStrobes_t       strobes,
  output logic [MEM_AW-1:0] rdIdx,
  output logic              frameSel,
  output logic              vintPending,
  output logic              irqOut
);
  logic               winHit;
  logic               pendSel;
  logic [OFS_W-1:0]   offset;

  assign winHit = cpuReq && ((cpuAddr & WIN_MASK) == WIN_BASE);
  assign offset = cpuAddr[OFS_W-1:0];
  assign rdIdx  = offset[MEM_AW:1];

  always_comb begin
    strobes.rdGo    = winHit;
    strobes.rdByte  = !cpuWide;
    strobes.oddByte = offset[0];
    strobes.bufSel  = !frameSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel     <= 1'b0;
      frameSel    <= 1'b0;
      vintPending <= 1'b0;
    end else begin
      if (ctrlWr) pendSel <= ctrlFrameSel;
      if (vblankStart) frameSel <= pendSel;
      if (vblankStart) vintPending <= 1'b1;
      else if (intAck) vintPending <= 1'b0;
    end
  end

  assign irqOut = vintPending && intEnable;

  // R6
  frame_moves_on_vblank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameSel) |-> $past(vblankStart));
  // R8
  vint_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> vintPending);
  // R9
  vint_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vintPending) |-> $past(vblankStart));
  // R10
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> vintPending);
endmodule

// File: rtl/fbDatapath.sv
module fbDatapath
  import fbPkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [MEM_AW-1:0] rdIdx,
  input  logic              fillEn,
  input  logic              fillBuf,
  input  logic [MEM_AW-1:0] fillIdx,
  input  logic [15:0]       fillData,
  output logic              rdValid,
  output logic [15:0]       rdData
);
  localparam int WORDS = 2 ** MEM_AW;
  localparam int NBUF  = 2;

  logic [15:0] bufWord [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [15:0] store [WORDS];
    always_ff @(posedge clk) begin
      if (fillEn && (fillBuf == b[0])) store[fillIdx] <= fillData;
    end
    assign bufWord[b] = store[rdIdx];
  end

  logic [15:0] selWord;
  logic [15:0] laneWord;

  assign selWord = bufWord[strobes.bufSel];

  always_comb begin
    if (!strobes.rdByte)      laneWord = selWord;
    else if (strobes.oddByte) laneWord = {8'h00, selWord[7:0]};
    else                      laneWord = {8'h00, selWord[15:8]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdGo;
      if (strobes.rdGo) rdData <= laneWord;
    end
  end
endmodule

// File: rtl/fbAccessPort.sv
module fbAccessPort
  import fbPkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [31:0]       cpuAddr,
  input  logic              cpuWide,
  output logic              rdValid,
  output logic [15:0]       rdData,
  input  logic              ctrlWr,
  input  logic              ctrlFrameSel,
  input  logic              vblankStart,
  input  logic              intEnable,
  input  logic              intAck,
  output logic              frameSel,
  output logic              vintPending,
  output logic              irqOut,
  input  logic              fillEn,
  input  logic              fillBuf,
  input  logic [MEM_AW-1:0] fillIdx,
  input  logic [15:0]       fillData
);
  ctlStrobes_t       strobes;
  logic [MEM_AW-1:0] rdIdx;

  fbControl #(.MEM_AW(MEM_AW)) uCtl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuWide(cpuWide),
    .ctrlWr(ctrlWr), .ctrlFrameSel(ctrlFrameSel), .vblankStart(vblankStart),
    .intEnable(intEnable), .intAck(intAck), .strobes(strobes), .rdIdx(rdIdx),
    .frameSel(frameSel), .vintPending(vintPending), .irqOut(irqOut)
  );

  fbDatapath #(.MEM_AW(MEM_AW)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdIdx(rdIdx),
    .fillEn(fillEn), .fillBuf(fillBuf), .fillIdx(fillIdx), .fillData(fillData),
    .rdValid(rdValid), .rdData(rdData)
  );

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(cpuReq));
  // R5
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !$past(cpuWide)) |-> (rdData[15:8] == 8'h00));
endmodule

// File: tb/fbAccessPort_test.sv
module fbAccessPort_test;
  localparam int AW = 10;
  localparam int WORDS = 2 ** AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWide = 1'b0, ctrlWr = 1'b0, ctrlFrameSel = 1'b0;
  logic vblankStart = 1'b0, intEnable = 1'b0, intAck = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic fillEn = 1'b0, fillBuf = 1'b0;
  logic [AW-1:0] fillIdx = '0;
  logic [15:0] fillData = '0;
  logic rdValid, frameSel, vintPending, irqOut;
  logic [15:0] rdData;

  int errors = 0;
  int checks = 0;
  bit expDisp = 1'b0;

  typedef struct { logic [15:0] data; string tag; } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  fbAccessPort #(.MEM_AW(AW)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuWide(cpuWide),
    .rdValid(rdValid), .rdData(rdData), .ctrlWr(ctrlWr), .ctrlFrameSel(ctrlFrameSel),
    .vblankStart(vblankStart), .intEnable(intEnable), .intAck(intAck),
    .frameSel(frameSel), .vintPending(vintPending), .irqOut(irqOut),
    .fillEn(fillEn), .fillBuf(fillBuf), .fillIdx(fillIdx), .fillData(fillData)
  );

  function automatic logic [15:0] pat(input bit b, input int i);
    logic [15:0] v;
    v = 16'(i * 16'h0123 + 16'h5A3C);
    return b ? ~v : v;
  endfunction

  function automatic logic [15:0] model(input bit b, input logic [31:0] a, input bit wide);
    logic [16:0] o;
    logic [15:0] w;
    o = a[16:0];
    w = pat(b, int'(o[16:1]) % WORDS);
    if (wide) return w;
    return o[0] ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [31:0] a, input bit wide, input string tag);
    expItem_t it;
    @(negedge clk);
    it.data = model(!expDisp, a, wide);
    it.tag = tag;
    expQ.push_back(it);
    cpuReq = 1'b1; cpuAddr = a; cpuWide = wide;
    @(negedge clk);
    cpuReq = 1'b0;
  endtask

  task automatic doMiss(input logic [31:0] a, input string tag);
    @(negedge clk);
    cpuReq = 1'b1; cpuAddr = a; cpuWide = 1'b1;
    @(negedge clk);
    cpuReq = 1'b0;
    #1 check(tag, 32'(rdValid), 32'd0);
  endtask

  task automatic pulse(input bit vb, input bit ack, input bit wr, input bit sel);
    @(negedge clk);
    vblankStart = vb; intAck = ack; ctrlWr = wr; ctrlFrameSel = sel;
    @(negedge clk);
    vblankStart = 1'b0; intAck = 1'b0; ctrlWr = 1'b0;
  endtask

  // monitor: pops expected read results as responses appear
  always @(negedge clk) begin
    #1;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected response %h expected=none", rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, 32'(rdData), 32'(it.data));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R3 reset frameSel", 32'(frameSel), 0);
    check("R8 reset vint", 32'(vintPending), 0);
    check("R10 reset irq", 32'(irqOut), 0);
    check("R2 reset rdValid", 32'(rdValid), 0);

    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < WORDS; i++) begin
        @(negedge clk);
        fillEn = 1'b1; fillBuf = b[0]; fillIdx = AW'(i); fillData = pat(b[0], i);
      end
    end
    @(negedge clk);
    fillEn = 1'b0;

    // R4 R3 16-bit reads from buffer 1
    doRead(32'h04000000, 1'b1, "R4 wide idx0");
    doRead(32'h04000246, 1'b1, "R4 wide idx 0x123");
    doRead(32'h0401FFFE, 1'b1, "R4 wrap top offset");
    // R5 byte lanes
    doRead(32'h04000010, 1'b0, "R5 byte even");
    doRead(32'h04000011, 1'b0, "R5 byte odd");
    // R1 aliases
    doRead(32'h24000100, 1'b1, "R1 alias 2x");
    doRead(32'hA4000101, 1'b0, "R1 alias Ax byte");
    doMiss(32'h04020000, "R1 miss above window");
    doMiss(32'h06000000, "R1 miss other region");
    // back-to-back reads
    @(negedge clk);
    expQ.push_back('{model(1'b1, 32'h04000020, 1'b1), "R2 back-to-back a"});
    cpuReq = 1'b1; cpuAddr = 32'h04000020; cpuWide = 1'b1;
    @(negedge clk);
    expQ.push_back('{model(1'b1, 32'h04000023, 1'b0), "R2 back-to-back b"});
    cpuAddr = 32'h04000023; cpuWide = 1'b0;
    @(negedge clk);
    cpuReq = 1'b0;
    #1 check("R2 single-cycle valid", 32'(rdValid), 1);
    @(negedge clk);
    #1 check("R2 valid drops", 32'(rdValid), 0);

    // R6 deferred flip
    pulse(1'b0, 1'b0, 1'b1, 1'b1);
    #1 check("R6 no flip on write", 32'(frameSel), 0);
    doRead(32'h04000040, 1'b1, "R6 still buffer1");
    intEnable = 1'b0;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    #1;
    expDisp = 1'b1;
    check("R6 flip at vblank", 32'(frameSel), 1);
    check("R8 vint set", 32'(vintPending), 1);
    check("R10 irq masked", 32'(irqOut), 0);
    @(negedge clk); intEnable = 1'b1;
    #1 check("R10 irq enabled", 32'(irqOut), 1);
    doRead(32'h04000040, 1'b1, "R3 now buffer0");
    doRead(32'h04000041, 1'b0, "R5 byte odd buffer0");

    // R9 ack clears, ack vs vblank collision
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    #1 check("R9 ack clears", 32'(vintPending), 0);
    check("R10 irq low after ack", 32'(irqOut), 0);
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    #1 check("R9 set wins over ack", 32'(vintPending), 1);
    check("R6 same pending keeps frame", 32'(frameSel), 1);

    // R7 write and vblank same cycle: old pending (1) applies
    pulse(1'b1, 1'b0, 1'b1, 1'b0);
    #1 check("R7 old pending applied", 32'(frameSel), 1);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    #1 check("R7 new value at next vblank", 32'(frameSel), 0);
    expDisp = 1'b0;

    // R11 read in the same cycle as a flip
    pulse(1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    expQ.push_back('{model(1'b1, 32'h04000088, 1'b1), "R11 read at flip uses old"});
    cpuReq = 1'b1; cpuAddr = 32'h04000088; cpuWide = 1'b1; vblankStart = 1'b1;
    @(negedge clk);
    cpuReq = 1'b0; vblankStart = 1'b0;
    expDisp = 1'b1;
    #1 check("R11 flip done", 32'(frameSel), 1);
    doRead(32'h04000088, 1'b1, "R11 read after flip");

    repeat (3) @(negedge clk);
    check("R2 all responses seen", 32'(expQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule